// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between the configuration software path of a PCI Express root port and two downstream targets: the root port's own register space, and an outbound translation window that turns a memory access into a configuration transaction on the link. A caller presents one request made up of bus, device and function numbers, a byte offset, a read/write flag and write data. The block vets the request, routes it, and returns one response word.

A request that fails a check causes no downstream access at all. A read that fails returns all ones, and a write that fails is discarded. Bus 0 goes to the local register space. Any other bus first programs the window with a transaction type and a target address, and the window access is issued on the following cycle. When a downstream access aborts, the read response becomes all ones. The block handles one request at a time and shows this on `busy`.

Top module: `cfg_xlat`

## Requirements
- R1: A request whose offset is 4096 or larger is rejected. A rejected read responds with 0xFFFFFFFF, and no local or window strobe is raised.
- R2: While `link_up` is low, a request to any bus other than 0 is rejected. Bus 0 requests are still served.
- R3: On bus 0 and bus 1, a request with a device number other than 0 is rejected.
- R4: An accepted bus 0 request raises `loc_req`. `loc_addr` carries the offset with bits 1:0 cleared, and `loc_write` and `loc_wdata` carry the request's write flag and data.
- R5: An accepted request to bus 1 or higher goes only to the window. `win_type1` is 0 for bus 1 and 1 for bus 2 and higher.
- R6: `win_target` equals bus<<24 | device<<19 | function<<16. This is the 24-bit tag (bus 23:16, device 15:11, function 10:8) shifted left by 8. `win_addr` is the word-aligned offset.
- R7: `win_cfg_we` pulses for exactly the one cycle before `win_req` first rises, and never in a cycle where `win_req` is high. `win_target` stays stable while `win_req` is high.
- R8: For a read, the response is the downstream read data, or 0xFFFFFFFF when the downstream access completes with its abort flag set. A write response word is 0.
- R9: `busy` is high from the edge that accepts a request until the cycle after `rsp_valid` pulses. A `req_valid` while `busy` is high is ignored and gives neither an access nor a response.
- R10: A rejected write produces a single `rsp_valid` pulse and no downstream access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 16 | Byte offset in configuration space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| link_up | input | 1 | Link trained indication |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Response word |
| loc_req | output | 1 | Local register access, held until loc_done |
| loc_write | output | 1 | Local access direction |
| loc_addr | output | 12 | Local word-aligned byte address |
| loc_wdata | output | 32 | Local write data |
| loc_done | input | 1 | Local access complete |
| loc_abort | input | 1 | Local access aborted, valid with loc_done |
| loc_rdata | input | 32 | Local read data, valid with loc_done |
| win_cfg_we | output | 1 | Window programming strobe |
| win_type1 | output | 1 | Window transaction type: 0 type-0, 1 type-1 |
| win_target | output | 32 | Window target address |
| win_req | output | 1 | Window access, held until win_done |
| win_write | output | 1 | Window access direction |
| win_addr | output | 12 | Window word-aligned byte offset |
| win_wdata | output | 32 | Window write data |
| win_done | input | 1 | Window access complete |
| win_abort | input | 1 | Window access aborted, valid with win_done |
| win_rdata | input | 32 | Window read data, valid with win_done |

## Verification
Two functions can fall in the same cycle: a downstream completion, and a new request from the caller arriving while the block is still busy. The bench holds `req_valid` high for a bus 3 request during a stretched local access and through the response cycle. It then confirms that the pending local read returns its own data exactly once, and that no window programming, window access or second response follows. The bench checks window ordering by looking at `win_cfg_we` in the cycle before each `win_req` rises.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
    parameter int BUS_W  = 8;
    parameter int DEV_W  = 5;
    parameter int FN_W   = 3;
    parameter int OFF_W  = 16;
    parameter int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOC,
        ST_WCFG,
        ST_WIN,
        ST_RESP
    } xl_state_e;

    typedef struct packed {
        xl_state_e           st;
        logic [BUS_W-1:0]    bus;
        logic [DEV_W-1:0]    dev;
        logic [FN_W-1:0]     fn;
        logic [OFF_W-1:0]    off;
        logic                write;
        logic                type1;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } xl_regs_t;
endpackage

// File: rtl/cfg_xlat_vet.sv
module cfg_xlat_vet
    import cfg_xlat_pkg::*;
#(
    parameter int EXT_CFG_BYTES = 4096
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [OFF_W-1:0] off,
    input  logic             link_up,
    output logic             pass,
    output logic             to_local,
    output logic             use_type1
);
    localparam logic [OFF_W-1:0] OFF_LIMIT = OFF_W'(EXT_CFG_BYTES);

    logic off_ok, link_ok, dev_ok;

    always_comb begin
        off_ok    = (off < OFF_LIMIT);
        link_ok   = (bus == '0) || link_up;
        dev_ok    = (bus > BUS_W'(1)) || (dev == '0);
        pass      = off_ok && link_ok && dev_ok;
        to_local  = (bus == '0);
        use_type1 = (bus > BUS_W'(1));
    end
endmodule

// File: rtl/cfg_xlat_tgt.sv
module cfg_xlat_tgt
    import cfg_xlat_pkg::*;
#(
    parameter int TGT_W   = 32,
    parameter int TAG_SH  = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    output logic [TGT_W-1:0] target
);
    localparam int TAG_W = BUS_W + DEV_W + FN_W + 8;

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag    = {bus, dev, fn, 8'h00};
        target = TGT_W'({tag, {TAG_SH{1'b0}}});
    end
endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int EXT_CFG_BYTES = 4096,
    parameter int TGT_W         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              link_up,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              loc_req,
    output logic              loc_write,
    output logic [$clog2(EXT_CFG_BYTES)-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_done,
    input  logic              loc_abort,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              win_cfg_we,
    output logic              win_type1,
    output logic [TGT_W-1:0]  win_target,
    output logic              win_req,
    output logic              win_write,
    output logic [$clog2(EXT_CFG_BYTES)-1:0] win_addr,
    output logic [DATA_W-1:0] win_wdata,
    input  logic              win_done,
    input  logic              win_abort,
    input  logic [DATA_W-1:0] win_rdata
);
    localparam int CFG_AW = $clog2(EXT_CFG_BYTES);

    xl_regs_t r_d, r_q;
    logic     v_pass, v_local, v_type1;
    logic [CFG_AW-1:0] word_addr;

    cfg_xlat_vet #(.EXT_CFG_BYTES(EXT_CFG_BYTES)) u_vet (
        .bus       (req_bus),
        .dev       (req_dev),
        .off       (req_off),
        .link_up   (link_up),
        .pass      (v_pass),
        .to_local  (v_local),
        .use_type1 (v_type1)
    );

    cfg_xlat_tgt #(.TGT_W(TGT_W)) u_tgt (
        .bus    (r_q.bus),
        .dev    (r_q.dev),
        .fn     (r_q.fn),
        .target (win_target)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.bus   = req_bus;
                    r_d.dev   = req_dev;
                    r_d.fn    = req_fn;
                    r_d.off   = req_off;
                    r_d.write = req_write;
                    r_d.wdata = req_wdata;
                    r_d.type1 = v_type1;
                    if (!v_pass) begin
                        r_d.rdata = req_write ? '0 : '1;
                        r_d.st    = ST_RESP;
                    end else if (v_local) begin
                        r_d.st    = ST_LOC;
                    end else begin
                        r_d.st    = ST_WCFG;
                    end
                end
            end
            ST_LOC: begin
                if (loc_done) begin
                    r_d.rdata = r_q.write ? '0 : (loc_abort ? '1 : loc_rdata);
                    r_d.st    = ST_RESP;
                end
            end
            ST_WCFG: r_d.st = ST_WIN;
            ST_WIN: begin
                if (win_done) begin
                    r_d.rdata = r_q.write ? '0 : (win_abort ? '1 : win_rdata);
                    r_d.st    = ST_RESP;
                end
            end
            ST_RESP: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q       <= r_d;
        end
    end

    assign word_addr  = {r_q.off[CFG_AW-1:2], 2'b00};
    assign busy       = (r_q.st != ST_IDLE);
    assign rsp_valid  = (r_q.st == ST_RESP);
    assign rsp_rdata  = r_q.rdata;
    assign loc_req    = (r_q.st == ST_LOC);
    assign loc_write  = r_q.write;
    assign loc_addr   = word_addr;
    assign loc_wdata  = r_q.wdata;
    assign win_cfg_we = (r_q.st == ST_WCFG);
    assign win_type1  = r_q.type1;
    assign win_req    = (r_q.st == ST_WIN);
    assign win_write  = r_q.write;
    assign win_addr   = word_addr;
    assign win_wdata  = r_q.wdata;

    // R9: the response cycle is followed by an idle block
    assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);

    // R7: window programmed in the cycle before the access starts
    assert_cfg_before_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_req) |-> $past(win_cfg_we));

    // R7: target held steady across the access
    assert_target_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && $past(win_req)) |-> $stable(win_target));

    // R5: the two downstream paths never overlap
    assert_path_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_req && (win_req || win_cfg_we)));

    // R2: the window is only programmed for a request accepted with the link up
    assert_link_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_cfg_we |-> $past(link_up));

    // R8: an aborted local read yields all ones
    assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !loc_write && $past(loc_req && loc_done && loc_abort))
            |-> (rsp_rdata == '1));
endmodule

// File: tb/cfg_xlat_tb.sv
module cfg_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [15:0] req_off = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        link_up = 1'b0;
    logic        busy, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        loc_req, loc_write;
    logic [11:0] loc_addr;
    logic [31:0] loc_wdata;
    logic        loc_done = 1'b0, loc_abort = 1'b0;
    logic [31:0] loc_rdata = '0;
    logic        win_cfg_we, win_type1, win_req, win_write;
    logic [31:0] win_target;
    logic [11:0] win_addr;
    logic [31:0] win_wdata;
    logic        win_done = 1'b0, win_abort = 1'b0;
    logic [31:0] win_rdata = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cfg_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_write(req_write), .req_wdata(req_wdata), .link_up(link_up),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .loc_req(loc_req), .loc_write(loc_write), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_done(loc_done), .loc_abort(loc_abort),
        .loc_rdata(loc_rdata), .win_cfg_we(win_cfg_we), .win_type1(win_type1),
        .win_target(win_target), .win_req(win_req), .win_write(win_write),
        .win_addr(win_addr), .win_wdata(win_wdata), .win_done(win_done),
        .win_abort(win_abort), .win_rdata(win_rdata)
    );

    typedef struct packed {
        logic        link;
        logic        wr;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [15:0] off;
        logic        abort;
        logic [1:0]  route;   // 0 rejected, 1 local, 2 window
        logic        t1;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'd0,   5'd0,  3'd0, 16'h0010, 1'b0, 2'd1, 1'b0},
        '{1'b1, 1'b1, 8'd0,   5'd0,  3'd0, 16'h0FFF, 1'b0, 2'd1, 1'b0},
        '{1'b1, 1'b0, 8'd0,   5'd1,  3'd0, 16'h0000, 1'b0, 2'd0, 1'b0},
        '{1'b1, 1'b0, 8'd1,   5'd0,  3'd2, 16'h0104, 1'b0, 2'd2, 1'b0},
        '{1'b1, 1'b0, 8'd1,   5'd3,  3'd0, 16'h0004, 1'b0, 2'd0, 1'b0},
        '{1'b0, 1'b0, 8'd1,   5'd0,  3'd0, 16'h0004, 1'b0, 2'd0, 1'b0},
        '{1'b0, 1'b0, 8'd0,   5'd0,  3'd0, 16'h0008, 1'b0, 2'd1, 1'b0},
        '{1'b1, 1'b0, 8'd2,   5'd5,  3'd7, 16'h0040, 1'b0, 2'd2, 1'b1},
        '{1'b1, 1'b1, 8'd255, 5'd31, 3'd1, 16'h0200, 1'b0, 2'd2, 1'b1},
        '{1'b1, 1'b0, 8'd0,   5'd0,  3'd0, 16'h1000, 1'b0, 2'd0, 1'b0},
        '{1'b1, 1'b1, 8'd3,   5'd0,  3'd0, 16'h1000, 1'b0, 2'd0, 1'b0},
        '{1'b1, 1'b0, 8'd0,   5'd0,  3'd0, 16'h0020, 1'b1, 2'd1, 1'b0},
        '{1'b1, 1'b0, 8'd4,   5'd2,  3'd3, 16'h0080, 1'b1, 2'd2, 1'b1},
        '{1'b1, 1'b0, 8'd4,   5'd2,  3'd3, 16'h0FFE, 1'b0, 2'd2, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // observed per request
    bit          seen_loc, seen_win, seen_cfg, prev_cfg, order_ok, stable_ok, rsp_seen;
    logic [11:0] got_addr;
    logic [31:0] got_wdata, got_tgt, rsp_data;
    logic        got_wr, got_t1;

    task automatic run_one(input vec_t v, input logic [31:0] wd, input int stall);
        seen_loc = 0; seen_win = 0; seen_cfg = 0; prev_cfg = 0;
        order_ok = 1; stable_ok = 1; rsp_seen = 0;
        got_addr = '0; got_wdata = '0; got_tgt = '0; rsp_data = '0;
        got_wr = 0; got_t1 = 0;
        link_up = v.link; req_valid = 1'b1; req_bus = v.bus; req_dev = v.dev;
        req_fn = v.fn; req_off = v.off; req_write = v.wr; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 30; k++) begin
            loc_done = 1'b0; win_done = 1'b0;
            if (rsp_valid) begin
                rsp_seen = 1; rsp_data = rsp_rdata;
                break;
            end
            if (loc_req) begin
                seen_loc = 1; got_addr = loc_addr; got_wdata = loc_wdata; got_wr = loc_write;
                if (k >= stall) begin
                    loc_done = 1'b1; loc_abort = v.abort;
                    loc_rdata = 32'hC0DE0000 ^ {20'h0, loc_addr};
                end
            end
            if (win_cfg_we) begin
                seen_cfg = 1; got_t1 = win_type1; got_tgt = win_target;
            end
            if (win_req) begin
                if (!seen_win && !prev_cfg) order_ok = 0;
                if (win_cfg_we) order_ok = 0;
                if (win_target != got_tgt) stable_ok = 0;
                seen_win = 1; got_addr = win_addr; got_wdata = win_wdata; got_wr = win_write;
                if (k >= stall) begin
                    win_done = 1'b1; win_abort = v.abort;
                    win_rdata = 32'h5EED0000 ^ {20'h0, win_addr};
                end
            end
            prev_cfg = win_cfg_we;
            @(posedge clk); @(negedge clk);
        end
        loc_done = 1'b0; win_done = 1'b0;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        chk(0, "WDOG", "watchdog expired", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] exp_rd, exp_tgt, wd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R9
        chk(!busy && !rsp_valid, "R9", "idle after reset", {busy, rsp_valid}, 0);
        chk(!loc_req && !win_req && !win_cfg_we, "R7", "no strobes after reset",
            {loc_req, win_req, win_cfg_we}, 0);

        for (int i = 0; i < NV; i++) begin
            wd = 32'hA0000000 + i;
            run_one(VEC[i], wd, i % 3);
            chk(rsp_seen, "R9", "response delivered", rsp_seen, 1);
            if (VEC[i].route == 2'd0) begin
                // R1 R2 R3 R10: no downstream access
                chk(!seen_loc && !seen_win && !seen_cfg, "R1_R2_R3_R10", "rejected, no access",
                    {seen_loc, seen_win, seen_cfg}, 0);
                exp_rd = VEC[i].wr ? 32'h0 : 32'hFFFFFFFF;
                chk(rsp_data == exp_rd, "R1", "rejected response", rsp_data, exp_rd);
            end else begin
                exp_rd = VEC[i].wr ? 32'h0 :
                         VEC[i].abort ? 32'hFFFFFFFF :
                         (((VEC[i].route == 2'd1) ? 32'hC0DE0000 : 32'h5EED0000)
                          ^ {20'h0, VEC[i].off[11:2], 2'b00});
                chk(rsp_data == exp_rd, "R8", "response word", rsp_data, exp_rd);
                chk(got_addr == {VEC[i].off[11:2], 2'b00}, "R4", "word aligned address",
                    got_addr, {VEC[i].off[11:2], 2'b00});
                chk(got_wr == VEC[i].wr && got_wdata == wd, "R4", "direction and data",
                    got_wdata, wd);
                if (VEC[i].route == 2'd1) begin
                    chk(seen_loc && !seen_win && !seen_cfg, "R4", "local route",
                        {seen_loc, seen_win, seen_cfg}, 3'b100);
                end else begin
                    chk(seen_win && seen_cfg && !seen_loc, "R5", "window route",
                        {seen_loc, seen_win, seen_cfg}, 3'b011);
                    chk(got_t1 == VEC[i].t1, "R5", "transaction type", got_t1, VEC[i].t1);
                    exp_tgt = {VEC[i].bus, VEC[i].dev, VEC[i].fn, 16'h0000};
                    chk(got_tgt == exp_tgt, "R6", "window target", got_tgt, exp_tgt);
                    chk(order_ok && stable_ok, "R7", "program before access",
                        {order_ok, stable_ok}, 2'b11);
                end
            end
            @(posedge clk); @(negedge clk);
            chk(!busy, "R9", "busy released", busy, 0);
        end

        // R9: new request held during a stretched access and its response cycle
        begin
            vec_t v0;
            int   extra;
            v0 = '{1'b1, 1'b0, 8'd0, 5'd0, 3'd0, 16'h0030, 1'b0, 2'd1, 1'b0};
            link_up = 1'b1; req_valid = 1'b1; req_bus = 8'd0; req_dev = '0; req_fn = '0;
            req_off = v0.off; req_write = 1'b0; req_wdata = '0;
            @(posedge clk); @(negedge clk);
            req_bus = 8'd3; req_off = 16'h0050;     // stays valid while busy
            chk(busy && loc_req, "R9", "busy during access", {busy, loc_req}, 2'b11);
            repeat (2) begin @(posedge clk); @(negedge clk); end
            chk(busy && loc_req && !win_cfg_we, "R9", "held request ignored",
                {busy, loc_req, win_cfg_we}, 3'b110);
            loc_done = 1'b1; loc_abort = 1'b0; loc_rdata = 32'h12345678;
            @(posedge clk); @(negedge clk);
            loc_done = 1'b0;
            // response cycle: req_valid still high here and must be ignored
            chk(rsp_valid && rsp_rdata == 32'h12345678, "R9", "pending read answered",
                rsp_rdata, 32'h12345678);
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            extra = 0;
            for (int k = 0; k < 5; k++) begin
                if (win_cfg_we || win_req || loc_req || rsp_valid) extra++;
                @(posedge clk); @(negedge clk);
            end
            chk(extra == 0 && !busy, "R9", "no access from request seen while busy",
                extra, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule